// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sequences the power modes of a small processor subsystem and drives the clock-enable signals that feed its clock gates. Software loads a power control register that holds a 2-bit target-mode field, one clock-enable bit per peripheral, one doze-gating bit per peripheral, and an enable bit for the external clock output. Writing the mode field only arms the target mode. The mode takes effect on the cycle after the core reports, with a one-cycle strobe, that it has executed its stop instruction.

While the block is in a low-power mode, the core clock is idle. Peripheral clocks, the system clock and the external clock pin are gated according to the active mode. Any of the following returns the block to normal running, with every enable restored on the next clock edge: a breakpoint request, a debug-request bit, a valid interrupt, or a synchronous software reset request. The software reset request also returns the register to its reset values. All enables are flop outputs, so they change once per cycle and never glitch. A status output reports the mode that is currently active.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset the active mode is RUN (code 00). The core, system and external-clock enables are 1, and every peripheral enable is 1.
- R2: The mode field uses the codes 00=RUN, 01=WAIT, 10=DOZE and 11=STOP. A register write does not change the active mode.
- R3: When the stop strobe is high and the armed mode is not RUN, the active mode equals the armed mode in the following cycle.
- R4: A stop strobe while the armed mode is RUN has no effect on the active mode or on any enable.
- R5: In WAIT the core enable is 0. The system enable is 1, each peripheral enable equals its register bit, and the external clock enable equals its register bit.
- R6: In DOZE the core enable is 0. Each peripheral enable equals its enable bit AND NOT its doze-gating bit.
- R7: In STOP the core, system, external-clock and all peripheral enables are 0, so the external clock pin is held low.
- R8: In any low-power mode, a breakpoint, debug-request or interrupt input that is high returns the active mode and all enables to their RUN values at the next clock edge.
- R9: A software reset request forces the active mode to RUN and returns every register field to its reset value.
- R10: A wakeup input that is high in the same cycle as the stop strobe cancels entry, and the mode stays RUN.
- R11: In RUN each peripheral enable follows its own register bit, independently of the others.
- R12: In RUN the external clock enable follows its register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_mode_i | input | 2 | Target mode written to the register |
| cfg_pen_i | input | NUM_PERIPH | Peripheral clock-enable bits |
| cfg_doze_off_i | input | NUM_PERIPH | Doze-gating bits |
| cfg_clkout_en_i | input | 1 | External clock output enable bit |
| stop_i | input | 1 | Core executed its stop instruction (one-cycle strobe) |
| bkpt_i | input | 1 | Breakpoint wakeup request |
| dbg_req_i | input | 1 | Debug-request register bit |
| irq_i | input | 1 | Valid interrupt request |
| sw_rst_i | input | 1 | Synchronous software reset request |
| core_clk_en_o | output | 1 | Core clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| clkout_en_o | output | 1 | External clock pin enable (0 holds the pin low) |
| periph_clk_en_o | output | NUM_PERIPH | Per-peripheral clock enables |
| mode_o | output | 2 | Currently active mode |

## Verification
The bench targets a stop strobe while RUN is armed. A design that treated that strobe as entry would idle the core with nothing pending. It also targets a wakeup in the same cycle as the stop strobe. If the design let that wakeup lose, the core would sleep past an interrupt. Each wakeup source is tried on its own, and a design that missed one would never leave that mode. The bench also checks DOZE masking against mixed enable and doze bit patterns, and checks that a software reset clears the register. A design that kept the old fields would re-enter the previous mode on the next stop strobe.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_DOZE = 2'b10,
    PM_STOP = 2'b11
  } pm_mode_e;
endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
  import lpm_pkg::*;
#(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sw_rst_i,
  input  logic                  we_i,
  input  logic [1:0]            mode_i,
  input  logic [NUM_PERIPH-1:0] pen_i,
  input  logic [NUM_PERIPH-1:0] doze_off_i,
  input  logic                  clkout_en_i,
  output pm_mode_e              mode_q_o,
  output pm_mode_e              mode_d_o,
  output logic [NUM_PERIPH-1:0] pen_d_o,
  output logic [NUM_PERIPH-1:0] doze_off_d_o,
  output logic                  clkout_en_d_o
);
  localparam logic [NUM_PERIPH-1:0] PEN_RST = {NUM_PERIPH{1'b1}};

  pm_mode_e              mode_q, mode_d;
  logic [NUM_PERIPH-1:0] pen_q, pen_d;
  logic [NUM_PERIPH-1:0] doff_q, doff_d;
  logic                  cke_q, cke_d;

  always_comb begin
    mode_d = mode_q;
    pen_d  = pen_q;
    doff_d = doff_q;
    cke_d  = cke_q;
    if (sw_rst_i) begin
      mode_d = PM_RUN;
      pen_d  = PEN_RST;
      doff_d = '0;
      cke_d  = 1'b1;
    end else if (we_i) begin
      mode_d = pm_mode_e'(mode_i);
      pen_d  = pen_i;
      doff_d = doze_off_i;
      cke_d  = clkout_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_RUN;
      pen_q  <= PEN_RST;
      doff_q <= '0;
      cke_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      pen_q  <= pen_d;
      doff_q <= doff_d;
      cke_q  <= cke_d;
    end
  end

  assign mode_q_o      = mode_q;
  assign mode_d_o      = mode_d;
  assign pen_d_o       = pen_d;
  assign doze_off_d_o  = doff_d;
  assign clkout_en_d_o = cke_d;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     stop_i,
  input  logic     wake_i,
  input  logic     sw_rst_i,
  input  pm_mode_e armed_i,
  output pm_mode_e act_q_o,
  output pm_mode_e act_d_o
);
  pm_mode_e act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (sw_rst_i || wake_i) begin
      act_d = PM_RUN;
    end else if (act_q == PM_RUN && stop_i && armed_i != PM_RUN) begin
      act_d = armed_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= PM_RUN;
    else         act_q <= act_d;
  end

  assign act_q_o = act_q;
  assign act_d_o = act_d;
endmodule

// File: rtl/lpm_gate_en.sv
module lpm_gate_en
  import lpm_pkg::*;
#(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  pm_mode_e              mode_i,
  input  logic [NUM_PERIPH-1:0] pen_i,
  input  logic [NUM_PERIPH-1:0] doze_off_i,
  input  logic                  clkout_en_i,
  output logic                  core_en_o,
  output logic                  sys_en_o,
  output logic                  clkout_en_o,
  output logic [NUM_PERIPH-1:0] periph_en_o
);
  logic core_d, sys_d, cko_d, core_q, sys_q, cko_q;
  logic in_doze, in_stop;

  assign in_doze = (mode_i == PM_DOZE);
  assign in_stop = (mode_i == PM_STOP);

  always_comb begin
    core_d = (mode_i == PM_RUN);
    sys_d  = !in_stop;
    cko_d  = clkout_en_i && !in_stop;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q <= 1'b1;
      sys_q  <= 1'b1;
      cko_q  <= 1'b1;
    end else begin
      core_q <= core_d;
      sys_q  <= sys_d;
      cko_q  <= cko_d;
    end
  end

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_periph
    logic en_d, en_q;
    assign en_d = pen_i[g] && !in_stop && !(in_doze && doze_off_i[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b1;
      else         en_q <= en_d;
    end
    assign periph_en_o[g] = en_q;
  end

  assign core_en_o   = core_q;
  assign sys_en_o    = sys_q;
  assign clkout_en_o = cko_q;
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [1:0]            cfg_mode_i,
  input  logic [NUM_PERIPH-1:0] cfg_pen_i,
  input  logic [NUM_PERIPH-1:0] cfg_doze_off_i,
  input  logic                  cfg_clkout_en_i,
  input  logic                  stop_i,
  input  logic                  bkpt_i,
  input  logic                  dbg_req_i,
  input  logic                  irq_i,
  input  logic                  sw_rst_i,
  output logic                  core_clk_en_o,
  output logic                  sys_clk_en_o,
  output logic                  clkout_en_o,
  output logic [NUM_PERIPH-1:0] periph_clk_en_o,
  output logic [1:0]            mode_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  pm_mode_e              armed_q, armed_d, act_q, act_d;
  logic [NUM_PERIPH-1:0] pen_d, doff_d;
  logic                  cke_d, wake;

  assign wake = bkpt_i | dbg_req_i | irq_i;

  lpm_cfg_reg #(.NUM_PERIPH(NUM_PERIPH)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .sw_rst_i     (sw_rst_i),
    .we_i         (cfg_we_i),
    .mode_i       (cfg_mode_i),
    .pen_i        (cfg_pen_i),
    .doze_off_i   (cfg_doze_off_i),
    .clkout_en_i  (cfg_clkout_en_i),
    .mode_q_o     (armed_q),
    .mode_d_o     (armed_d),
    .pen_d_o      (pen_d),
    .doze_off_d_o (doff_d),
    .clkout_en_d_o(cke_d)
  );

  lpm_mode_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .stop_i  (stop_i),
    .wake_i  (wake),
    .sw_rst_i(sw_rst_i),
    .armed_i (armed_q),
    .act_q_o (act_q),
    .act_d_o (act_d)
  );

  lpm_gate_en #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .mode_i     (act_d),
    .pen_i      (pen_d),
    .doze_off_i (doff_d),
    .clkout_en_i(cke_d),
    .core_en_o  (core_clk_en_o),
    .sys_en_o   (sys_clk_en_o),
    .clkout_en_o(clkout_en_o),
    .periph_en_o(periph_clk_en_o)
  );

  assign mode_o = act_q;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
  parameter int NUM_PERIPH = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  stop_i,
  input logic                  bkpt_i,
  input logic                  dbg_req_i,
  input logic                  irq_i,
  input logic                  sw_rst_i,
  input logic                  core_clk_en_o,
  input logic                  sys_clk_en_o,
  input logic                  clkout_en_o,
  input logic [NUM_PERIPH-1:0] periph_clk_en_o,
  input logic [1:0]            mode_o
);
  logic any_wake;
  assign any_wake = bkpt_i | dbg_req_i | irq_i | sw_rst_i;

  AST_CORE_IDLE_IN_LP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'b00) |-> !core_clk_en_o); // R5

  AST_STOP_ALL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |-> (!sys_clk_en_o && !clkout_en_o && periph_clk_en_o == '0)); // R7

  AST_WAKE_TO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_wake && mode_o != 2'b00) |=> (mode_o == 2'b00 && core_clk_en_o)); // R8

  AST_CANCEL_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && any_wake) |=> (mode_o == 2'b00)); // R10

  AST_RUN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && !stop_i) |=> (mode_o == 2'b00)); // R2

  AST_RUN_CORE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b00 && !stop_i) |=> core_clk_en_o); // R4
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stop_i         (stop_i),
  .bkpt_i         (bkpt_i),
  .dbg_req_i      (dbg_req_i),
  .irq_i          (irq_i),
  .sw_rst_i       (sw_rst_i),
  .core_clk_en_o  (core_clk_en_o),
  .sys_clk_en_o   (sys_clk_en_o),
  .clkout_en_o    (clkout_en_o),
  .periph_clk_en_o(periph_clk_en_o),
  .mode_o         (mode_o)
);

// File: tb/lpm_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_clk_ctrl_tb_top;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          we, cke, stop, bkpt, dbg, irq, swr;
  logic [1:0]    md;
  logic [NP-1:0] pen, doff;
  logic          core_en, sys_en, cko_en;
  logic [NP-1:0] per_en;
  logic [1:0]    mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lpm_clk_ctrl #(.NUM_PERIPH(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_mode_i(md),
    .cfg_pen_i(pen), .cfg_doze_off_i(doff), .cfg_clkout_en_i(cke),
    .stop_i(stop), .bkpt_i(bkpt), .dbg_req_i(dbg), .irq_i(irq),
    .sw_rst_i(swr), .core_clk_en_o(core_en), .sys_clk_en_o(sys_en),
    .clkout_en_o(cko_en), .periph_clk_en_o(per_en), .mode_o(mode)
  );

  // expected output vector {mode, core, sys, clkout, periph}
  function automatic logic [8:0] expv(input logic [1:0] m, input logic [NP-1:0] p,
                                      input logic [NP-1:0] d, input logic c);
    logic [NP-1:0] pe;
    case (m)
      2'b00: return {m, 1'b1, 1'b1, c, p};
      2'b01: return {m, 1'b0, 1'b1, c, p};
      2'b10: begin pe = p & ~d; return {m, 1'b0, 1'b1, c, pe}; end
      default: return {m, 1'b0, 1'b0, 1'b0, {NP{1'b0}}};
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] exp);
    logic [8:0] act;
    act = {mode, core_en, sys_en, cko_en, per_en};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] m, input logic [NP-1:0] p,
                    input logic [NP-1:0] d, input logic c);
    we = 1'b1; md = m; pen = p; doff = d; cke = c;
    cyc();
    we = 1'b0;
  endtask

  task automatic pulse_stop(); stop = 1'b1; cyc(); stop = 1'b0; endtask

  task automatic t_reset();
    check("R1", expv(2'b00, 4'hF, 4'h0, 1'b1));
  endtask

  task automatic t_arm_only();
    wr(2'b11, 4'hF, 4'h0, 1'b1);
    check("R2", expv(2'b00, 4'hF, 4'h0, 1'b1));
    cyc();
    check("R2", expv(2'b00, 4'hF, 4'h0, 1'b1));
  endtask

  task automatic t_wait();
    wr(2'b01, 4'b1010, 4'h0, 1'b1);
    pulse_stop();
    check("R3", expv(2'b01, 4'b1010, 4'h0, 1'b1));
    cyc();
    check("R5", expv(2'b01, 4'b1010, 4'h0, 1'b1));
    irq = 1'b1; cyc(); irq = 1'b0;
    check("R8", expv(2'b00, 4'b1010, 4'h0, 1'b1));
  endtask

  task automatic t_doze();
    wr(2'b10, 4'b1110, 4'b0110, 1'b0);
    pulse_stop();
    check("R6", expv(2'b10, 4'b1110, 4'b0110, 1'b0));
    bkpt = 1'b1; cyc(); bkpt = 1'b0;
    check("R8", expv(2'b00, 4'b1110, 4'b0110, 1'b0));
  endtask

  task automatic t_stop();
    wr(2'b11, 4'hF, 4'h0, 1'b1);
    pulse_stop();
    check("R7", expv(2'b11, 4'hF, 4'h0, 1'b1));
    cyc(); cyc();
    check("R7", expv(2'b11, 4'hF, 4'h0, 1'b1));
    dbg = 1'b1; cyc(); dbg = 1'b0;
    check("R8", expv(2'b00, 4'hF, 4'h0, 1'b1));
  endtask

  task automatic t_stop_in_run();
    wr(2'b00, 4'b0101, 4'hF, 1'b1);
    pulse_stop();
    check("R4", expv(2'b00, 4'b0101, 4'hF, 1'b1));
  endtask

  task automatic t_cancel();
    wr(2'b11, 4'hF, 4'h0, 1'b1);
    stop = 1'b1; irq = 1'b1; cyc(); stop = 1'b0; irq = 1'b0;
    check("R10", expv(2'b00, 4'hF, 4'h0, 1'b1));
    cyc();
    check("R10", expv(2'b00, 4'hF, 4'h0, 1'b1));
  endtask

  task automatic t_sw_rst();
    wr(2'b10, 4'b0011, 4'b0001, 1'b0);
    pulse_stop();
    check("R6", expv(2'b10, 4'b0011, 4'b0001, 1'b0));
    swr = 1'b1; cyc(); swr = 1'b0;
    check("R9", expv(2'b00, 4'hF, 4'h0, 1'b1));
    pulse_stop();
    check("R9", expv(2'b00, 4'hF, 4'h0, 1'b1));
  endtask

  task automatic t_periph_clkout();
    for (int i = 0; i < NP; i++) begin
      logic [NP-1:0] p;
      p = ~(4'b0001 << i);
      wr(2'b00, p, 4'h0, 1'b1);
      check("R11", expv(2'b00, p, 4'h0, 1'b1));
    end
    wr(2'b00, 4'hF, 4'h0, 1'b0);
    check("R12", expv(2'b00, 4'hF, 4'h0, 1'b0));
    wr(2'b00, 4'hF, 4'h0, 1'b1);
    check("R12", expv(2'b00, 4'hF, 4'h0, 1'b1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; md = 2'b00; pen = '0; doff = '0; cke = 1'b0;
    stop = 1'b0; bkpt = 1'b0; dbg = 1'b0; irq = 1'b0; swr = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    t_reset();
    t_arm_only();
    t_wait();
    t_doze();
    t_stop();
    t_stop_in_run();
    t_cancel();
    t_sw_rst();
    t_periph_clkout();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule